// File: doc/BRIEF.md
# Single-Descriptor Buffer Mover for a Flash Data Path

This block moves one buffer of bytes between system memory and the byte stream of a flash interface. Software stores a four-word descriptor in memory and writes its address into the block's base register. A start pulse then makes the block fetch the descriptor over its 64-bit memory read port. The block checks that the descriptor is handed to hardware and describes one whole buffer. It then transfers the buffer. In transmit mode, memory words are read and sent out as bytes, low byte first. In receive mode, incoming bytes are packed into 64-bit words and written to memory.

At the end of the transfer the block writes the status word back with the hardware-ownership bit cleared. It then gives a one-cycle completion pulse whose output depends on the direction. A descriptor that is not handed to hardware, or that is not a complete single buffer, moves no data and produces a separate error pulse. The descriptor must sit on an 8-byte boundary. Memory accesses use 64-bit words. Descriptor word 0 (status) is in bits 31:0 and word 1 (sizes) in bits 63:32 of the first word. Buffer pointer 0 is in bits 31:0 of the second word. The second pointer, in bits 63:32, is never used.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset the block is idle: `busy`, `mrd_req`, `mwr_req`, `tx_valid`, `rx_ready`, `tx_done`, `rx_done` and `desc_unavail` are all low.
- R2: A `start` pulse while idle fetches the descriptor with two reads. The first read is at the latched base address and the second at base+8. Status is taken from bits 31:0 of the first word, sizes from bits 63:32, and buffer pointer 0 from bits 31:0 of the second word. Bits 63:32 of the second word are ignored.
- R3: If status bit 31 (hardware owns) is clear, the block moves no data and does not write the status back. It pulses `desc_unavail` for one cycle and returns to idle.
- R4: Status bits 3 (first) and 2 (last) must both be set. Otherwise the descriptor is rejected exactly as in R3.
- R5: The number of 8-byte beats is sizes bits 11:3. Sizes bits 31:12 and 2:0 are ignored. With zero beats the block moves no data, but it still writes the status back and pulses the completion output.
- R6: In transmit mode (`dir_rx`=0 at start), the block reads 8-byte words upward from buffer pointer 0. It sends each word as 8 bytes on `tx_data`, byte k taken from bits 8k+7:8k, in the order k=0..7, with a valid/ready handshake. `tx_data` stays stable while `tx_valid` is high and `tx_ready` is low.
- R7: In receive mode (`dir_rx`=1 at start), the block accepts bytes through a valid/ready handshake and places byte k of each group of eight into bits 8k+7:8k. It writes each full word with strobe 0xFF upward from buffer pointer 0.
- R8: After the last beat, the block writes the status word back to the descriptor base. The write uses strobe 0x0F, with bit 31 cleared and every other status bit unchanged. The sizes word is not altered.
- R9: After the status write is acknowledged, the block raises exactly one one-cycle pulse: `tx_done` for transmit or `rx_done` for receive. At most one of `tx_done`, `rx_done` and `desc_unavail` is high in any cycle.
- R10: A `start` while busy is ignored. A base-register write while busy updates the register, which the next start uses. The descriptor of the current transfer keeps the address latched at its own start.
- R11: A memory read or write request is held, with its address stable, until its acknowledge. Read and write requests are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Write strobe for the descriptor base register |
| base_wdata | input | 32 | Descriptor base address (8-byte aligned) |
| start | input | 1 | Start pulse, taken only while idle |
| dir_rx | input | 1 | Direction at start: 0 transmit, 1 receive |
| busy | output | 1 | High from start until the block is idle again |
| mrd_req | output | 1 | Memory read request |
| mrd_addr | output | 32 | Memory read byte address |
| mrd_ack | input | 1 | Read acknowledge, data valid in the same cycle |
| mrd_data | input | 64 | Read data |
| mwr_req | output | 1 | Memory write request |
| mwr_addr | output | 32 | Memory write byte address |
| mwr_data | output | 64 | Write data |
| mwr_strb | output | 8 | Byte-lane write enables |
| mwr_ack | input | 1 | Write acknowledge |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Flash side accepts transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block accepts receive byte |
| tx_done | output | 1 | One-cycle transmit completion pulse |
| rx_done | output | 1 | One-cycle receive completion pulse |
| desc_unavail | output | 1 | One-cycle pulse for a rejected descriptor |

## Verification
A wrong beat counter or pointer shows up at the ports within one memory access. It appears as a missing or extra byte on the transmit stream, or as a memory word written to the wrong address. A broken byte index in the serializer or packer produces a wrong byte order on the first word. A wrong ownership or flag decision shows up in the cycle after the second descriptor read. In that cycle the wrong pulse appears, or data moves that should not. A lost status latch appears only at the final write-back, as a wrong status value in memory. The bench therefore checks the memory contents after every completion.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
    localparam int BUS_BYTES = 8;
    localparam int BUS_W     = BUS_BYTES * 8;
    localparam int OWN_BIT   = 31;
    localparam int FIRST_BIT = 3;
    localparam int LAST_BIT  = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH0,
        S_FETCH1,
        S_CHECK,
        S_TX_RD,
        S_TX_SEND,
        S_RX_FILL,
        S_RX_WR,
        S_WBACK,
        S_DONE
    } state_e;
endpackage

// File: rtl/dma_tx_unpack.sv
module dma_tx_unpack #(
    parameter int BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BYTES*8-1:0] load_data,
    output logic               out_valid,
    output logic [7:0]         out_data,
    input  logic               out_ready,
    output logic               last_take
);
    localparam int W     = BYTES * 8;
    localparam int IDX_W = $clog2(BYTES);

    typedef struct packed {
        logic [W-1:0]     word;
        logic [IDX_W-1:0] idx;
        logic             full;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d         = q;
        last_take = 1'b0;
        if (load) begin
            d.word = load_data;
            d.idx  = '0;
            d.full = 1'b1;
        end else if (q.full && out_ready) begin
            if (q.idx == IDX_W'(BYTES - 1)) begin
                d.full    = 1'b0;
                d.idx     = '0;
                last_take = 1'b1;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
        out_valid = q.full;
        out_data  = q.word[q.idx*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6
    tx_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !out_valid);
endmodule

// File: rtl/dma_rx_pack.sv
module dma_rx_pack #(
    parameter int BYTES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               word_done,
    output logic [BYTES*8-1:0] word
);
    localparam int W     = BYTES * 8;
    localparam int IDX_W = $clog2(BYTES);

    typedef struct packed {
        logic [W-1:0]     word;
        logic [IDX_W-1:0] idx;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d         = q;
        word_done = 1'b0;
        if (en && in_valid) begin
            d.word[q.idx*8 +: 8] = in_data;
            if (q.idx == IDX_W'(BYTES - 1)) begin
                d.idx     = '0;
                word_done = 1'b1;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
        in_ready = en;
        word     = q.word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    rx_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(word));
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
    import dma_desc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              start,
    input  logic              dir_rx,
    output logic              busy,
    output logic              mrd_req,
    output logic [ADDR_W-1:0] mrd_addr,
    input  logic              mrd_ack,
    input  logic [BUS_W-1:0]  mrd_data,
    output logic              mwr_req,
    output logic [ADDR_W-1:0] mwr_addr,
    output logic [BUS_W-1:0]  mwr_data,
    output logic [BUS_BYTES-1:0] mwr_strb,
    input  logic              mwr_ack,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_done,
    output logic              rx_done,
    output logic              desc_unavail
);
    localparam int IDX_W  = $clog2(BUS_BYTES);
    localparam int BEAT_W = SIZE_W - IDX_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BUS_BYTES);
    localparam logic [31:0] OWN_MASK = 32'h1 << OWN_BIT;

    typedef struct packed {
        state_e            st;
        logic              dir_rx;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] desc;
        logic [31:0]       status;
        logic [BEAT_W-1:0] beats;
        logic [ADDR_W-1:0] ptr;
    } regs_t;

    regs_t q, d;

    logic             load_tx;
    logic             tx_last;
    logic             rx_en;
    logic             rx_word_done;
    logic [BUS_W-1:0] rx_word;
    logic             desc_ok;

    always_comb begin
        d        = q;
        load_tx  = 1'b0;
        mrd_req  = 1'b0;
        mrd_addr = '0;
        mwr_req  = 1'b0;
        mwr_addr = '0;
        mwr_data = '0;
        mwr_strb = '0;
        desc_ok  = q.status[OWN_BIT] && q.status[FIRST_BIT] && q.status[LAST_BIT];
        rx_en    = (q.st == S_RX_FILL);

        if (base_wr) d.base = base_wdata;

        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st     = S_FETCH0;
                    d.dir_rx = dir_rx;
                    d.desc   = q.base;
                end
            end
            S_FETCH0: begin
                mrd_req  = 1'b1;
                mrd_addr = q.desc;
                if (mrd_ack) begin
                    d.status = mrd_data[31:0];
                    d.beats  = mrd_data[32+SIZE_W-1 -: BEAT_W];
                    d.st     = S_FETCH1;
                end
            end
            S_FETCH1: begin
                mrd_req  = 1'b1;
                mrd_addr = q.desc + STEP;
                if (mrd_ack) begin
                    d.ptr = mrd_data[ADDR_W-1:0];
                    d.st  = S_CHECK;
                end
            end
            S_CHECK: begin
                if (!desc_ok)              d.st = S_IDLE;
                else if (q.beats == '0)    d.st = S_WBACK;
                else if (q.dir_rx)         d.st = S_RX_FILL;
                else                       d.st = S_TX_RD;
            end
            S_TX_RD: begin
                mrd_req  = 1'b1;
                mrd_addr = q.ptr;
                if (mrd_ack) begin
                    load_tx = 1'b1;
                    d.st    = S_TX_SEND;
                end
            end
            S_TX_SEND: begin
                if (tx_last) begin
                    d.beats = q.beats - 1'b1;
                    d.ptr   = q.ptr + STEP;
                    d.st    = (q.beats == BEAT_W'(1)) ? S_WBACK : S_TX_RD;
                end
            end
            S_RX_FILL: begin
                if (rx_word_done) d.st = S_RX_WR;
            end
            S_RX_WR: begin
                mwr_req  = 1'b1;
                mwr_addr = q.ptr;
                mwr_data = rx_word;
                mwr_strb = '1;
                if (mwr_ack) begin
                    d.beats = q.beats - 1'b1;
                    d.ptr   = q.ptr + STEP;
                    d.st    = (q.beats == BEAT_W'(1)) ? S_WBACK : S_RX_FILL;
                end
            end
            S_WBACK: begin
                mwr_req  = 1'b1;
                mwr_addr = q.desc;
                mwr_data = {{(BUS_W-32){1'b0}}, q.status & ~OWN_MASK};
                mwr_strb = BUS_BYTES'(8'h0F);
                if (mwr_ack) d.st = S_DONE;
            end
            S_DONE: begin
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        busy         = (q.st != S_IDLE);
        tx_done      = (q.st == S_DONE) && !q.dir_rx;
        rx_done      = (q.st == S_DONE) && q.dir_rx;
        desc_unavail = (q.st == S_CHECK) && !desc_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    dma_tx_unpack #(.BYTES(BUS_BYTES)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_tx),
        .load_data (mrd_data),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_ready (tx_ready),
        .last_take (tx_last)
    );

    dma_rx_pack #(.BYTES(BUS_BYTES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .in_valid  (rx_valid),
        .in_data   (rx_data),
        .in_ready  (rx_ready),
        .word_done (rx_word_done),
        .word      (rx_word)
    );

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req && !mrd_ack) |=> (mrd_req && $stable(mrd_addr)));

    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_req && !mwr_ack) |=> (mwr_req && $stable(mwr_addr) && $stable(mwr_data)));

    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mrd_req && mwr_req));

    // R9
    event_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_done, rx_done, desc_unavail}));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done || rx_done) |=> !(tx_done || rx_done));

    // R3
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_unavail |=> !busy);

    // R8
    wback_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_req && mwr_strb == BUS_BYTES'(8'h0F)) |-> !mwr_data[OWN_BIT]);

    // R3
    reject_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_unavail |-> (!tx_valid && !mwr_req));
endmodule

// File: tb/dma_desc_engine_tb.sv
module dma_desc_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        start = 1'b0;
    logic        dir_rx = 1'b0;
    logic        busy;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_ack = 1'b0;
    logic [63:0] mrd_data = '0;
    logic        mwr_req;
    logic [31:0] mwr_addr;
    logic [63:0] mwr_data;
    logic [7:0]  mwr_strb;
    logic        mwr_ack = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_done, rx_done, desc_unavail;

    always #4 clk = ~clk;

    dma_desc_engine u_dut (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
        .start(start), .dir_rx(dir_rx), .busy(busy),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
        .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_strb(mwr_strb),
        .mwr_ack(mwr_ack), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_done(tx_done), .rx_done(rx_done), .desc_unavail(desc_unavail)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: one process owns every write
    logic [63:0] mem [0:511];
    logic        host_we = 1'b0;
    logic [31:0] host_addr = '0;
    logic [63:0] host_data = '0;
    int          wait_cfg = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;

    always @(posedge clk) begin
        if (host_we) mem[host_addr[11:3]] <= host_data;
        if (!rst_n) begin
            mrd_ack <= 1'b0;
            mwr_ack <= 1'b0;
            rd_cnt  <= 0;
            wr_cnt  <= 0;
        end else begin
            mrd_ack <= 1'b0;
            mwr_ack <= 1'b0;
            if (mrd_req && !mrd_ack) begin
                if (rd_cnt < wait_cfg) rd_cnt <= rd_cnt + 1;
                else begin
                    rd_cnt   <= 0;
                    mrd_ack  <= 1'b1;
                    mrd_data <= mem[mrd_addr[11:3]];
                end
            end
            if (mwr_req && !mwr_ack) begin
                if (wr_cnt < wait_cfg) wr_cnt <= wr_cnt + 1;
                else begin
                    logic [63:0] w;
                    wr_cnt  <= 0;
                    mwr_ack <= 1'b1;
                    w = mem[mwr_addr[11:3]];
                    for (int k = 0; k < 8; k++)
                        if (mwr_strb[k]) w[8*k +: 8] = mwr_data[8*k +: 8];
                    mem[mwr_addr[11:3]] <= w;
                end
            end
        end
    end

    // scoreboard queues and event counters
    logic [7:0] exp_q[$];
    logic [7:0] rx_q[$];
    int  n_tx_done = 0, n_rx_done = 0, n_unavail = 0, n_rx_take = 0;
    bit  stall = 1'b0;
    bit  rx_pend = 1'b0;

    // monitor and stream side, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        tx_ready = stall ? (cyc % 4 != 3) : 1'b1;
        if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) check(1'b0, "R6 unexpected tx byte", {56'h0, tx_data}, 64'h0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(tx_data == e, "R6 tx byte order", {56'h0, tx_data}, {56'h0, e});
            end
        end
        if (tx_done) n_tx_done++;
        if (rx_done) n_rx_done++;
        if (desc_unavail) n_unavail++;
        if (rx_pend) begin
            void'(rx_q.pop_front());
            n_rx_take++;
        end
        rx_valid = (rx_q.size() > 0);
        rx_data  = rx_valid ? rx_q[0] : 8'h00;
        rx_pend  = rx_valid && rx_ready;
    end

    always @(posedge clk) begin
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return 8'(seed + i * 3);
    endfunction

    task automatic host_wr(input logic [31:0] a, input logic [63:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] a);
        @(negedge clk);
        base_wr = 1'b1; base_wdata = a;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] b, input logic [31:0] st, input logic [31:0] sz,
                            input logic [31:0] p0, input logic [31:0] p1);
        host_wr(b, {sz, st});
        host_wr(b + 8, {p1, p0});
    endtask

    // driver: loads buffer and pushes the bytes expected on the stream
    task automatic fill_tx(input logic [31:0] p, input logic [7:0] seed, input int words, input int expect_words);
        for (int w = 0; w < words; w++) begin
            logic [63:0] v;
            for (int k = 0; k < 8; k++) v[8*k +: 8] = pat(seed, w*8 + k);
            host_wr(p + 32'(w*8), v);
        end
        for (int i = 0; i < expect_words*8; i++) exp_q.push_back(pat(seed, i));
    endtask

    task automatic go(input bit rx);
        @(negedge clk);
        dir_rx = rx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_events(input int target, input string tag);
        int n;
        n = 0;
        while ((n_tx_done + n_rx_done + n_unavail) < target && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(n < 20000, tag, 64'(n), 64'(20000));
        repeat (6) @(negedge clk);
    endtask

    function automatic int ev_total();
        return n_tx_done + n_rx_done + n_unavail;
    endfunction

    initial begin
        int t;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!busy, "R1 busy after reset", 64'(busy), 0);
        check(!mrd_req && !mwr_req, "R1 no memory request", {62'h0, mrd_req, mwr_req}, 0);
        check(!tx_valid && !rx_ready, "R1 streams idle", {62'h0, tx_valid, rx_ready}, 0);
        check(!tx_done && !rx_done && !desc_unavail, "R1 no events", {61'h0, tx_done, rx_done, desc_unavail}, 0);
        rst_n = 1'b1;
        set_base(32'h0);

        // R6 R2 R8 R9: transmit 3 beats, pointer 1 garbage, extra status bits kept
        put_desc(32'h0, 32'h8000_013C, 32'd24, 32'h100, 32'hDEAD_BEE0);
        fill_tx(32'h100, 8'h10, 3, 3);
        t = ev_total();
        go(1'b0);
        wait_events(t + 1, "R9 tx completion seen");
        check(exp_q.size() == 0, "R6 all tx bytes sent", 64'(exp_q.size()), 0);
        check(n_tx_done == 1 && n_rx_done == 0, "R9 one tx_done only", {32'(n_tx_done), 32'(n_rx_done)}, {32'd1, 32'd0});
        check(mem[0][31:0] == 32'h0000_013C, "R8 status written back", 64'(mem[0][31:0]), 64'h13C);
        check(mem[0][63:32] == 32'd24, "R8 sizes untouched", 64'(mem[0][63:32]), 64'd24);
        check(mem[1] == {32'hDEAD_BEE0, 32'h100}, "R2 pointer word untouched", mem[1], {32'hDEAD_BEE0, 32'h100});

        // R7 receive 2 beats with wait states
        wait_cfg = 2;
        put_desc(32'h0, 32'h8000_000C, 32'd16, 32'h200, 32'h0);
        for (int i = 0; i < 16; i++) rx_q.push_back(pat(8'hA0, i));
        t = ev_total();
        go(1'b1);
        wait_events(t + 1, "R9 rx completion seen");
        for (int w = 0; w < 2; w++) begin
            logic [63:0] e;
            for (int k = 0; k < 8; k++) e[8*k +: 8] = pat(8'hA0, w*8 + k);
            check(mem[(32'h200 >> 3) + w] == e, "R7 rx word in memory", mem[(32'h200 >> 3) + w], e);
        end
        check(n_rx_done == 1, "R9 rx_done count", 64'(n_rx_done), 1);
        check(mem[0][31:0] == 32'h0000_000C, "R8 rx status written back", 64'(mem[0][31:0]), 64'hC);

        // R3 not owned: receive direction, bytes offered but must not be taken
        put_desc(32'h0, 32'h0000_000C, 32'd8, 32'h300, 32'h0);
        host_wr(32'h300, 64'h1111_1111_1111_1111);
        for (int i = 0; i < 8; i++) rx_q.push_back(8'h55);
        t = n_rx_take;
        go(1'b1);
        wait_events(ev_total() + 1, "R3 reject event seen");
        check(n_unavail == 1, "R3 desc_unavail pulse", 64'(n_unavail), 1);
        check(n_rx_take == t, "R3 no rx byte taken", 64'(n_rx_take), 64'(t));
        check(mem[32'h300 >> 3] == 64'h1111_1111_1111_1111, "R3 buffer untouched", mem[32'h300 >> 3], 64'h1111_1111_1111_1111);
        check(mem[0][31:0] == 32'h0000_000C, "R3 no write-back", 64'(mem[0][31:0]), 64'hC);
        rx_q.delete();
        repeat (3) @(negedge clk);

        // R4 last set but first clear: rejected, no tx bytes (monitor flags any)
        wait_cfg = 0;
        put_desc(32'h0, 32'h8000_0004, 32'd8, 32'h100, 32'h0);
        go(1'b0);
        wait_events(ev_total() + 1, "R4 reject event seen");
        check(n_unavail == 2 && n_tx_done == 1, "R4 rejected", {32'(n_unavail), 32'(n_tx_done)}, {32'd2, 32'd1});
        check(mem[0][31:0] == 32'h8000_0004, "R4 no write-back", 64'(mem[0][31:0]), 64'h8000_0004);

        // R5 zero beats, upper size bits ignored
        put_desc(32'h0, 32'h8000_000C, 32'hABC0_0000, 32'h100, 32'h0);
        go(1'b0);
        wait_events(ev_total() + 1, "R5 zero-size completion seen");
        check(n_tx_done == 2, "R5 zero size completes", 64'(n_tx_done), 2);
        check(mem[0][31:0] == 32'h0000_000C, "R5 zero size write-back", 64'(mem[0][31:0]), 64'hC);

        // R5 low size bits ignored: 15 gives one beat
        put_desc(32'h0, 32'h8000_000C, 32'd15, 32'h100, 32'h0);
        fill_tx(32'h100, 8'h40, 2, 1);
        go(1'b0);
        wait_events(ev_total() + 1, "R5 truncated size completion seen");
        check(exp_q.size() == 0 && n_tx_done == 3, "R5 one beat sent", {32'(exp_q.size()), 32'(n_tx_done)}, {32'd0, 32'd3});

        // R10 start and base write while busy, with tx stalls and wait states
        wait_cfg = 1;
        stall = 1'b1;
        put_desc(32'h40, 32'h8000_000C, 32'd8, 32'h280, 32'h0);
        put_desc(32'h0, 32'h8000_000C, 32'd32, 32'h100, 32'h0);
        fill_tx(32'h100, 8'h77, 4, 4);
        t = ev_total();
        go(1'b0);
        repeat (15) @(negedge clk);
        check(busy, "R10 busy mid-transfer", 64'(busy), 1);
        set_base(32'h40);
        go(1'b1);
        wait_events(t + 1, "R10 transfer completion seen");
        repeat (40) @(negedge clk);
        check(ev_total() == t + 1 && !busy, "R10 second start ignored", 64'(ev_total()), 64'(t + 1));
        check(exp_q.size() == 0, "R6 stalled bytes all sent", 64'(exp_q.size()), 0);
        check(mem[0][31:0] == 32'h0000_000C, "R10 write-back at old base", 64'(mem[0][31:0]), 64'hC);
        check(mem[32'h40 >> 3][31:0] == 32'h8000_000C, "R10 new base untouched", 64'(mem[32'h40 >> 3][31:0]), 64'h8000_000C);
        stall = 1'b0;

        // R10 next start uses the new base
        for (int i = 0; i < 8; i++) rx_q.push_back(pat(8'h33, i));
        go(1'b1);
        wait_events(ev_total() + 1, "R10 new-base completion seen");
        begin
            logic [63:0] e;
            for (int k = 0; k < 8; k++) e[8*k +: 8] = pat(8'h33, k);
            check(mem[32'h280 >> 3] == e, "R7 rx via new base", mem[32'h280 >> 3], e);
        end
        check(mem[32'h40 >> 3][31:0] == 32'h0000_000C, "R10 write-back at new base", 64'(mem[32'h40 >> 3][31:0]), 64'hC);
        check(n_rx_done == 2, "R9 second rx_done", 64'(n_rx_done), 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule